// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the datapath half of a simple processor in which every transfer travels over one shared 32-bit bus. It holds a program counter, a memory address register, a memory data register, an instruction register, a 32 x 32 register file, an operand latch Y on the ALU's left side and a result latch Z on its output. It has no sequencer of its own. An external controller drives a set of enables in every cycle. These choose which source drives the bus, which registers capture the bus at the clock edge, what the ALU computes and whether a memory read starts.

The register file index is not a free input. It is taken from one field of the instruction register, and a two-bit select code picks the field. A controller can therefore name "the first source", "the second source" or "the destination" of the current instruction. A behavioural memory stub with a configurable latency is built in. The controller starts a read by asserting a read strobe while the address register holds the address. It then waits for a completion flag, after which the memory data register holds the word. A preload port fills the stub before a test.

Top module: `onebus_dp`

## Requirements
- R1: While `rst_n` is low, and after it is released, PC holds `RESET_PC` (default 0). MAR, MDR, IR, Y and Z read 0, and `mfc` and `bus_err` are low.
- R2: When exactly one of `drv_pc`, `drv_reg`, `drv_mdr` and `drv_z` is high, `bus_q` carries that source in the same cycle: PC, the selected register, MDR or Z. When none is high, `bus_q` is 0 and `bus_err` is low.
- R3: When two or more bus enables are high in one cycle, `bus_err` is high in that cycle. The bus then carries the highest-priority source, in the order Z, then MDR, then the register file, then PC.
- R4: `ld_pc`, `ld_mar`, `ld_ir` and `ld_y` each load their register with the bus value at the clock edge that ends the cycle. A register whose load enable is low keeps its value.
- R5: With `ld_z` high, Z captures f(Y, B) at the end of the cycle. B is the bus value, or the constant 4 when `use_const4` is high. `alu_op` 00 gives Y+B, 01 gives Y-B, 10 gives Y AND B and 11 gives Y OR B, all modulo 2^32.
- R6: The register index comes from the IR field chosen by `reg_sel`: 00 picks IR[25:21], 01 picks IR[20:16], 10 picks IR[15:11] and 11 picks register 0. `drv_reg` reads that register onto the bus. `wr_reg` writes the bus value into it at the end of the cycle.
- R7: Register 0 always reads as 0, and writes to it have no effect.
- R8: A cycle with `mem_rd` high starts a read of stub word MAR[7:2], and `mfc` is low in the following cycle. `mfc` is first high `MEM_LAT`+1 cycles after the request cycle, with MDR holding the word. MDR changes only when `mfc` rises.
- R9: With `pre_we` high, `pre_data` is written into stub word `pre_idx` at the clock edge, and a later read of that word returns it.
- R10: With `MEM_LAT` = 5, a fetch that overlaps the PC increment with the memory wait, followed by a three-cycle register add, takes 11 cycles. For the instruction word 0x00454020 this leaves register 8 equal to register 2 plus register 5, and PC advanced by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| drv_pc | input | 1 | PC drives the bus |
| drv_reg | input | 1 | Selected register drives the bus |
| drv_mdr | input | 1 | MDR drives the bus |
| drv_z | input | 1 | Z latch drives the bus |
| ld_pc | input | 1 | PC loads from the bus |
| ld_mar | input | 1 | MAR loads from the bus |
| ld_ir | input | 1 | IR loads from the bus |
| ld_y | input | 1 | Y loads from the bus |
| ld_z | input | 1 | Z loads the ALU result |
| wr_reg | input | 1 | Selected register loads from the bus |
| reg_sel | input | 2 | IR field used as register index |
| alu_op | input | 2 | ALU function |
| use_const4 | input | 1 | ALU right operand is 4 instead of the bus |
| mem_rd | input | 1 | Start a memory read at MAR |
| pre_we | input | 1 | Preload write strobe for the memory stub |
| pre_idx | input | MIDX_W (6) | Preload word index |
| pre_data | input | DATA_W (32) | Preload data |
| bus_q | output | DATA_W | Shared bus value |
| pc_q | output | DATA_W | Program counter |
| mar_q | output | DATA_W | Memory address register |
| mdr_q | output | DATA_W | Memory data register |
| ir_q | output | DATA_W | Instruction register |
| y_q | output | DATA_W | ALU operand latch |
| z_q | output | DATA_W | ALU result latch |
| mfc | output | 1 | Memory read complete |
| bus_err | output | 1 | More than one bus driver enabled |

## Verification
The bus value and `bus_err` are combinational, so they are due in the same cycle as the enables. The bench samples them one time unit after it changes the inputs, well before the next edge. Every register load, Z capture and register-file write is due at the edge that ends the cycle, and the bench samples it one time unit after that edge. `mfc` is due `MEM_LAT`+1 cycles after the request. The bench waits on it the way a sequencer would, repeating the PC-write state and counting the repeats, so a latency error shows up as a wrong count and is not masked by the waiting.

// File: rtl/onebus_pkg.sv
// Package: shared types and instruction-field positions for the single-bus datapath.
// Assumes a 32-bit instruction word with three 5-bit register fields.
package onebus_pkg;

    localparam int FIELD_W = 5;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    // Bus source slots; a higher index wins when several drive at once.
    localparam int SRC_PC  = 0;
    localparam int SRC_RF  = 1;
    localparam int SRC_MDR = 2;
    localparam int SRC_Z   = 3;
    localparam int NSRC    = 4;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_OR  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_FIRST  = 2'b00,
        SEL_SECOND = 2'b01,
        SEL_DEST   = 2'b10,
        SEL_ZERO   = 2'b11
    } reg_sel_e;

    // Extract the register index named by the select code from an instruction word.
    function automatic logic [FIELD_W-1:0] field_index(input logic [31:0] instr,
                                                        input reg_sel_e sel);
        logic [FIELD_W-1:0] idx;
        case (sel)
            SEL_FIRST:  idx = instr[RS_LSB +: FIELD_W];
            SEL_SECOND: idx = instr[RT_LSB +: FIELD_W];
            SEL_DEST:   idx = instr[RD_LSB +: FIELD_W];
            default:    idx = '0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/obd_bus_mux.sv
// Module: priority selector for the shared bus.
// Picks one source per cycle; the highest slot index among the enabled
// sources wins, and an idle bus reads zero. Flags any cycle with more than
// one enable. Purely combinational.
module obd_bus_mux
    import onebus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [NSRC-1:0]        drv,
    input  logic [NSRC-1:0][W-1:0] src,
    output logic [W-1:0]           bus,
    output logic                   multi
);

    // Walk the slots upward so the last enabled one (highest priority) remains.
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (drv[i]) begin
                bus = src[i];
            end
        end
    end

    // Count the enables to detect contention.
    always_comb begin
        multi = ($countones(drv) > 1);
    end

endmodule

// File: rtl/obd_alu.sv
// Module: two-operand ALU for the datapath.
// Left operand is the Y latch, right operand is the bus or a constant,
// chosen by the parent. Result is modulo 2^W. Combinational.
module obd_alu
    import onebus_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    // Apply the selected function.
    always_comb begin
        case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            default: res = a | b;
        endcase
    end

endmodule

// File: rtl/obd_regfile.sv
// Module: general register file, one read port and one write port.
// Entry 0 is a hard zero; all other entries reset to zero. Read is
// combinational, the write lands at the clock edge.
module obd_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data
);

    logic [W-1:0] word_q [NREG];

    assign word_q[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_entry
        logic [W-1:0] q;

        // Hold one register; load when this entry is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end

        assign word_q[g] = q;
    end

    // Read the addressed entry.
    always_comb begin
        rd_data = word_q[rd_idx];
    end

endmodule

// File: rtl/obd_mem_stub.sv
// Module: behavioural word memory with fixed read latency.
// A request restarts the countdown; completion is signalled for one cycle
// as 'fire' together with the data, LAT cycles after the request edge.
// Assumes LAT >= 1. The array is filled through the preload port only.
module obd_mem_stub #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    parameter int LAT   = 5,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             fire,
    output logic [W-1:0]     rd_data,
    input  logic             pre_we,
    input  logic [IDX_W-1:0] pre_idx,
    input  logic [W-1:0]     pre_data
);

    logic [W-1:0]     mem [WORDS];
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Preload writes into the array.
    always_ff @(posedge clk) begin
        if (pre_we) begin
            mem[pre_idx] <= pre_data;
        end
    end

    // Track the outstanding read and count down its latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (rd_req) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT);
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Completion in the last counted cycle, unless a new request preempts it.
    always_comb begin
        fire    = busy_q && (cnt_q == CNT_W'(1)) && !rd_req;
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/onebus_dp.sv
// Module: single-bus processor datapath (top).
// Holds PC, MAR, MDR, IR, the Y and Z latches, a register file and a
// latency-modelled memory stub. An external controller drives every
// enable each cycle. Assumes DATA_W >= 32 so the instruction fields exist,
// and DATA_W >= MIDX_W + 2 for the word address in MAR.
module onebus_dp
    import onebus_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          NREG      = 32,
    parameter int          MEM_WORDS = 64,
    parameter int          MEM_LAT   = 5,
    parameter int unsigned RESET_PC  = 0,
    localparam int RIDX_W = $clog2(NREG),
    localparam int MIDX_W = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_pc,
    input  logic              drv_reg,
    input  logic              drv_mdr,
    input  logic              drv_z,
    input  logic              ld_pc,
    input  logic              ld_mar,
    input  logic              ld_ir,
    input  logic              ld_y,
    input  logic              ld_z,
    input  logic              wr_reg,
    input  logic [1:0]        reg_sel,
    input  logic [1:0]        alu_op,
    input  logic              use_const4,
    input  logic              mem_rd,
    input  logic              pre_we,
    input  logic [MIDX_W-1:0] pre_idx,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] bus_q,
    output logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] z_q,
    output logic              mfc,
    output logic              bus_err
);

    localparam logic [DATA_W-1:0] CONST_STEP = DATA_W'(4);

    logic [NSRC-1:0]             drv_vec;
    logic [NSRC-1:0][DATA_W-1:0] src_vec;
    logic [RIDX_W-1:0]           rf_idx;
    logic [DATA_W-1:0]           rf_rdata;
    logic [DATA_W-1:0]           alu_b;
    logic [DATA_W-1:0]           alu_res;
    logic                        mem_fire;
    logic [DATA_W-1:0]           mem_rdata;
    logic [MIDX_W-1:0]           mar_word;

    // Gather the bus enables and source values into slot order.
    always_comb begin
        drv_vec          = '0;
        drv_vec[SRC_PC]  = drv_pc;
        drv_vec[SRC_RF]  = drv_reg;
        drv_vec[SRC_MDR] = drv_mdr;
        drv_vec[SRC_Z]   = drv_z;
        src_vec          = '0;
        src_vec[SRC_PC]  = pc_q;
        src_vec[SRC_RF]  = rf_rdata;
        src_vec[SRC_MDR] = mdr_q;
        src_vec[SRC_Z]   = z_q;
    end

    obd_bus_mux #(
        .W (DATA_W)
    ) u_bus (
        .drv   (drv_vec),
        .src   (src_vec),
        .bus   (bus_q),
        .multi (bus_err)
    );

    // Derive the register index from the IR field named by the select code.
    always_comb begin
        rf_idx = RIDX_W'(field_index(ir_q[31:0], reg_sel_e'(reg_sel)));
    end

    obd_regfile #(
        .W    (DATA_W),
        .NREG (NREG)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rf_idx),
        .rd_data (rf_rdata),
        .wr_en   (wr_reg),
        .wr_idx  (rf_idx),
        .wr_data (bus_q)
    );

    // Choose the ALU right operand: bus or the fixed step.
    always_comb begin
        alu_b = use_const4 ? CONST_STEP : bus_q;
    end

    obd_alu #(
        .W (DATA_W)
    ) u_alu (
        .op  (alu_op_e'(alu_op)),
        .a   (y_q),
        .b   (alu_b),
        .res (alu_res)
    );

    // Word address seen by memory.
    always_comb begin
        mar_word = mar_q[MIDX_W+1:2];
    end

    obd_mem_stub #(
        .W     (DATA_W),
        .WORDS (MEM_WORDS),
        .LAT   (MEM_LAT)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (mem_rd),
        .rd_idx   (mar_word),
        .fire     (mem_fire),
        .rd_data  (mem_rdata),
        .pre_we   (pre_we),
        .pre_idx  (pre_idx),
        .pre_data (pre_data)
    );

    // Program counter: loads from the bus on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= DATA_W'(RESET_PC);
        end else if (ld_pc) begin
            pc_q <= bus_q;
        end
    end

    // Address, instruction and operand registers: each loads from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            ir_q  <= '0;
            y_q   <= '0;
        end else begin
            if (ld_mar) begin
                mar_q <= bus_q;
            end
            if (ld_ir) begin
                ir_q <= bus_q;
            end
            if (ld_y) begin
                y_q <= bus_q;
            end
        end
    end

    // Result latch: captures the ALU output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
        end else if (ld_z) begin
            z_q <= alu_res;
        end
    end

    // Memory data register and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            mfc   <= 1'b0;
        end else begin
            if (mem_fire) begin
                mdr_q <= mem_rdata;
            end
            if (mem_rd) begin
                mfc <= 1'b0;
            end else if (mem_fire) begin
                mfc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/onebus_dp_chk.sv
// Module: property checker for the single-bus datapath, bound to the top.
// Observes ports only; assumes synchronous active-low reset.
module onebus_dp_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         drv_pc,
    input logic         drv_reg,
    input logic         drv_mdr,
    input logic         drv_z,
    input logic         ld_pc,
    input logic         ld_y,
    input logic         ld_z,
    input logic [1:0]   reg_sel,
    input logic [1:0]   alu_op,
    input logic         use_const4,
    input logic         mem_rd,
    input logic [W-1:0] bus_q,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] mdr_q,
    input logic [W-1:0] y_q,
    input logic [W-1:0] z_q,
    input logic         mfc,
    input logic         bus_err
);

    AST_ERR_NEEDS_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($countones({drv_z, drv_mdr, drv_reg, drv_pc}) > 1)); // R3
    AST_Z_HAS_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        drv_z |-> (bus_q == z_q)); // R3
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_z || drv_mdr || drv_reg || drv_pc) |-> (bus_q == '0 && !bus_err)); // R2
    AST_Y_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_y |=> (y_q == $past(bus_q))); // R4
    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pc |=> $stable(pc_q)); // R4
    AST_ADD_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_z && alu_op == 2'b00 && !use_const4) |=> (z_q == $past(y_q + bus_q))); // R5
    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_z && alu_op == 2'b00 && use_const4) |=> (z_q == $past(y_q + W'(4)))); // R5
    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_reg && !drv_z && !drv_mdr && reg_sel == 2'b11) |-> (bus_q == '0)); // R7
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mfc); // R8
    AST_MDR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdr_q) |-> $rose(mfc)); // R8

endmodule

bind onebus_dp onebus_dp_chk #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_pc     (drv_pc),
    .drv_reg    (drv_reg),
    .drv_mdr    (drv_mdr),
    .drv_z      (drv_z),
    .ld_pc      (ld_pc),
    .ld_y       (ld_y),
    .ld_z       (ld_z),
    .reg_sel    (reg_sel),
    .alu_op     (alu_op),
    .use_const4 (use_const4),
    .mem_rd     (mem_rd),
    .bus_q      (bus_q),
    .pc_q       (pc_q),
    .mdr_q      (mdr_q),
    .y_q        (y_q),
    .z_q        (z_q),
    .mfc        (mfc),
    .bus_err    (bus_err)
);

// File: tb/sim_onebus_dp.sv
// Bench: drives the datapath as a sequencer would and checks it against
// a model kept in bench variables, built from the requirements.
module sim_onebus_dp;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;
    localparam int MW         = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        drv_pc, drv_reg, drv_mdr, drv_z;
    logic        ld_pc, ld_mar, ld_ir, ld_y, ld_z, wr_reg;
    logic [1:0]  reg_sel, alu_op;
    logic        use_const4, mem_rd, pre_we;
    logic [5:0]  pre_idx;
    logic [31:0] pre_data;
    logic [31:0] bus_q, pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
    logic        mfc, bus_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    onebus_dp #(
        .MEM_WORDS (MW),
        .MEM_LAT   (LAT)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .drv_pc (drv_pc), .drv_reg (drv_reg), .drv_mdr (drv_mdr), .drv_z (drv_z),
        .ld_pc (ld_pc), .ld_mar (ld_mar), .ld_ir (ld_ir), .ld_y (ld_y), .ld_z (ld_z),
        .wr_reg (wr_reg), .reg_sel (reg_sel), .alu_op (alu_op),
        .use_const4 (use_const4), .mem_rd (mem_rd),
        .pre_we (pre_we), .pre_idx (pre_idx), .pre_data (pre_data),
        .bus_q (bus_q), .pc_q (pc_q), .mar_q (mar_q), .mdr_q (mdr_q), .ir_q (ir_q),
        .y_q (y_q), .z_q (z_q), .mfc (mfc), .bus_err (bus_err)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    logic [31:0] m_rf [32];
    logic [31:0] bm [MW];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {drv_pc, drv_reg, drv_mdr, drv_z} = '0;
        {ld_pc, ld_mar, ld_ir, ld_y, ld_z, wr_reg} = '0;
        reg_sel = 2'b00; alu_op = 2'b00; use_const4 = 1'b0; mem_rd = 1'b0;
        pre_we = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] f_alu(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        case (op)
            2'b00:   return a + b;
            2'b01:   return a - b;
            2'b10:   return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic logic [4:0] f_idx(input logic [31:0] ir, input logic [1:0] sel);
        case (sel)
            2'b00:   return ir[25:21];
            2'b01:   return ir[20:16];
            2'b10:   return ir[15:11];
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [31:0] f_enc(input logic [4:0] s, input logic [4:0] t,
                                          input logic [4:0] d);
        return {6'd0, s, t, d, 11'd0};
    endfunction

    // Preload one stub word (R9).
    task automatic poke(input logic [5:0] idx, input logic [31:0] data);
        idle(); pre_we = 1'b1; pre_idx = idx; pre_data = data;
        step();
        pre_we = 1'b0;
        bm[idx] = data;
    endtask

    // Overlapped fetch: request, PC+4 into Z, repeat Z->PC until done.
    task automatic fetch(output int waits);
        bit done;
        idle(); drv_pc = 1'b1; ld_mar = 1'b1; mem_rd = 1'b1; ld_y = 1'b1;
        step();
        m_mar = m_pc; m_y = m_pc;
        chk("R8 done low after request", {31'd0, mfc}, 32'd0);
        idle(); use_const4 = 1'b1; alu_op = 2'b00; ld_z = 1'b1;
        step();
        m_z = m_pc + 32'd4;
        waits = 0; done = 1'b0;
        while (!done && waits < 64) begin
            idle(); drv_z = 1'b1; ld_pc = 1'b1;
            #1;
            done = mfc;
            step();
            waits++;
        end
        m_pc = m_z;
        m_mdr = bm[m_mar[7:2]];
        chk("R8 MDR holds word", mdr_q, m_mdr);
        chk("R4 MAR took PC", mar_q, m_mar);
    endtask

    task automatic set_ir(input logic [31:0] word);
        int w;
        poke(m_pc[7:2], word);
        fetch(w);
        idle(); drv_mdr = 1'b1; ld_ir = 1'b1;
        step();
        m_ir = m_mdr;
        chk("R4 IR loaded", ir_q, m_ir);
    endtask

    task automatic load_reg(input logic [4:0] r, input logic [31:0] v);
        int w;
        set_ir(f_enc(5'd0, 5'd0, r));
        poke(m_pc[7:2], v);
        fetch(w);
        idle(); drv_mdr = 1'b1; reg_sel = 2'b10; wr_reg = 1'b1;
        step();
        if (r != 5'd0) m_rf[r] = v;
    endtask

    // Watchdog: a hung run ends as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        int cyc;
        logic [31:0] a, b;
        void'($urandom(32'h0b05_2024));
        idle(); pre_idx = '0; pre_data = '0;
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < MW; i++) bm[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: state during reset.
        chk("R1 PC", pc_q, 32'd0);
        chk("R1 MAR", mar_q, 32'd0);
        chk("R1 MDR", mdr_q, 32'd0);
        chk("R1 IR", ir_q, 32'd0);
        chk("R1 Y", y_q, 32'd0);
        chk("R1 Z", z_q, 32'd0);
        chk("R1 done", {31'd0, mfc}, 32'd0);
        chk("R2 idle bus", bus_q, 32'd0);
        chk("R1 err", {31'd0, bus_err}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 PC after release", pc_q, 32'd0);
        m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_y = 0; m_z = 0;

        // R10: fetch plus add, measured in cycles.
        a = $urandom; b = $urandom;
        load_reg(5'd2, a);
        load_reg(5'd5, b);
        poke(m_pc[7:2], 32'h0045_4020);
        fetch(w);
        chk("R8 latency repeats", w, LAT);
        cyc = 2 + w;
        idle(); drv_mdr = 1'b1; ld_ir = 1'b1; step(); cyc++;
        m_ir = m_mdr;
        idle(); drv_reg = 1'b1; reg_sel = 2'b00; ld_y = 1'b1; step(); cyc++;
        idle(); drv_reg = 1'b1; reg_sel = 2'b01; alu_op = 2'b00; ld_z = 1'b1; step(); cyc++;
        idle(); drv_z = 1'b1; reg_sel = 2'b10; wr_reg = 1'b1; step(); cyc++;
        m_rf[8] = a + b; m_y = a; m_z = a + b;
        chk("R10 cycle count", cyc, 32'd11);
        chk("R10 PC advanced", pc_q, m_pc);
        idle(); drv_reg = 1'b1; reg_sel = 2'b10; #1;
        chk("R10 reg8 sum", bus_q, a + b);

        // R7: zero register ignores writes, by field and by select code 11.
        load_reg(5'd0, 32'hdead_beef);
        idle(); drv_reg = 1'b1; reg_sel = 2'b10; #1;
        chk("R7 zero via field", bus_q, 32'd0);
        idle(); drv_mdr = 1'b1; reg_sel = 2'b11; wr_reg = 1'b1; step();
        idle(); drv_reg = 1'b1; reg_sel = 2'b11; #1;
        chk("R7 zero via code", bus_q, 32'd0);

        // R6: fill registers 1..7 and read each back by its destination field.
        for (int r = 1; r < 8; r++) begin
            load_reg(5'(r), $urandom);
            idle(); drv_reg = 1'b1; reg_sel = 2'b10; #1;
            chk("R6 write then read", bus_q, m_rf[r]);
        end

        // R2/R3: random enable patterns, no loads; nothing may change (R4).
        set_ir(f_enc(5'd3, 5'd6, 5'd1));
        for (int k = 0; k < 40; k++) begin
            logic [3:0] e;
            logic [1:0] s;
            logic [31:0] ex;
            e = 4'($urandom);
            s = 2'($urandom);
            if (k == 0) e = 4'b1111;
            if (k == 1) e = 4'b0110;
            idle(); {drv_z, drv_mdr, drv_reg, drv_pc} = e; reg_sel = s;
            #1;
            if (e[3]) ex = m_z;
            else if (e[2]) ex = m_mdr;
            else if (e[1]) ex = m_rf[f_idx(m_ir, s)];
            else if (e[0]) ex = m_pc;
            else ex = 32'd0;
            if ($countones(e) > 1) begin
                chk("R3 priority value", bus_q, ex);
                chk("R3 contention flag", {31'd0, bus_err}, 32'd1);
            end else begin
                chk("R2 single source value", bus_q, ex);
                chk("R2 no contention", {31'd0, bus_err}, 32'd0);
            end
            step();
            chk("R4 PC held", pc_q, m_pc);
            chk("R4 Y held", y_q, m_y);
        end

        // R5/R6: random ALU operations on register operands, write-back to rd.
        for (int k = 0; k < 30; k++) begin
            logic [4:0] i, j, d;
            logic [1:0] op;
            logic c;
            i = 5'($urandom_range(0, 7));
            j = 5'($urandom_range(0, 7));
            d = 5'($urandom_range(0, 7));
            op = 2'($urandom);
            c = 1'($urandom);
            set_ir(f_enc(i, j, d));
            idle(); drv_reg = 1'b1; reg_sel = 2'b00; ld_y = 1'b1; step();
            m_y = m_rf[i];
            chk("R6 first field into Y", y_q, m_y);
            idle(); drv_reg = 1'b1; reg_sel = 2'b01; alu_op = op; use_const4 = c; ld_z = 1'b1;
            step();
            m_z = f_alu(op, m_y, c ? 32'd4 : m_rf[j]);
            chk("R5 ALU result", z_q, m_z);
            idle(); drv_z = 1'b1; reg_sel = 2'b10; wr_reg = 1'b1; step();
            if (d != 5'd0) m_rf[d] = m_z;
            idle(); drv_reg = 1'b1; reg_sel = 2'b10; #1;
            if (d == 5'd0) chk("R7 write-back to zero", bus_q, 32'd0);
            else chk("R6 write-back", bus_q, m_rf[d]);
            chk("R4 PC held over ALU", pc_q, m_pc);
        end

        idle();
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule